// File: doc/BRIEF.md
# Run-Time Resizable Byte Buffer

This block is a byte-wide first-in first-out buffer meant to sit between a serial-line engine and the memory-transfer logic that fills or drains it. Its storage is always built at the largest depth, sixteen entries by default. A size register, written through plain control pins, chooses how many entries are in use: 1, 2, 4, 8 or 16. Entries above the chosen depth are gated off, and both pointers wrap at the chosen depth. The full flag therefore follows the live setting and not the physical array.

A depth is accepted only when it fits within the block-transfer limit that the `dma_blk_sel` input selects, and only while the buffer is empty. A rejected change leaves the buffer untouched. Three sticky error bits record rejected configuration writes, pushes into a full buffer and pops from an empty buffer. Software clears each bit by writing a 1 to the matching bit of `clr_mask`.

Back-pressure rules. On the write side, `in_valid` offers a byte. The byte is taken when `in_full` is low, or when a pop happens in the same cycle. A byte offered while full with no pop is dropped and sets the overflow bit, so the producer must hold `in_valid` low while `in_full` is high. On the read side, `out_valid` shows that `out_data` holds the oldest byte. `out_ready` acts as a read strobe: while `out_valid` is high it removes that byte, and while the buffer is empty it has no effect on the data but sets the underflow bit.

Top module: `rsz_byte_fifo`

## Requirements
- R1: Reset is synchronous and active high. After reset the size code is 4 (16 entries), `fill_level` is 0, `in_full` and `out_valid` are low, and all three error bits are 0.
- R2: Bytes leave in the order they were taken. While `out_valid` is high, `out_data` shows the oldest stored byte, and `out_valid` is high exactly when `fill_level` is not 0.
- R3: `in_full` is high exactly when `fill_level` equals the active depth.
- R4: A size code on `cfg_size` maps 0,1,2,3,4 to 1,2,4,8,16 entries, and `depth_code` reads back the active code. A configuration write with code 5, 6 or 7 is ignored and sets `err_cfg`.
- R5: `dma_blk_sel` values 0,1,2,3 give block limits of 4, 16, 64 and 128 bytes. A configuration write whose depth exceeds the selected limit is ignored and sets `err_cfg`.
- R6: A configuration write takes effect only when the buffer is empty and `in_valid` is low in that cycle. Otherwise it is ignored, sets `err_cfg`, and the stored bytes and their order are unchanged.
- R7: The read and write pointers wrap modulo the active depth. Data stays intact through any number of wraps at every depth.
- R8: A push while full with no pop in the same cycle is dropped and sets `err_ovf`. A pop while empty is ignored and sets `err_unf`.
- R9: The error bits are sticky. `clr_mask` bit 0 clears `err_cfg`, bit 1 clears `err_ovf` and bit 2 clears `err_unf`. A new error event in the same cycle as its clear leaves the bit set.
- R10: A push and a pop in the same cycle while full both complete, and `fill_level` stays at the depth.
- R11: `fill_level` gives the occupancy from 0 to 16. It changes in the cycle after each accepted push or pop, and it is unchanged after a cycle with both a push and a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Byte offered for writing |
| in_valid | input | 1 | Write request |
| in_full | output | 1 | All enabled entries are occupied |
| out_data | output | 8 | Oldest stored byte |
| out_valid | output | 1 | Buffer holds at least one byte |
| out_ready | input | 1 | Read strobe |
| cfg_we | input | 1 | Strobe that writes the size register |
| cfg_size | input | 3 | Requested size code |
| dma_blk_sel | input | 2 | Block-transfer limit select |
| depth_code | output | 3 | Active size code |
| fill_level | output | 5 | Current occupancy |
| err_cfg | output | 1 | Sticky: configuration write was rejected |
| err_ovf | output | 1 | Sticky: push arrived while full |
| err_unf | output | 1 | Sticky: pop arrived while empty |
| clr_mask | input | 3 | Write-1-to-clear strobes for the error bits |

## Verification
The bench sweeps every legal depth and tries each with four traffic patterns. The first fills the buffer to the brim, which shows where the full flag moves. The second pushes and pops together while full, which tells a pass-through apart from a stall. The third is a long run of push-plus-pop at full occupancy, which wraps the pointers several times and exposes any wrap at 16 instead of at the active depth. The fourth is an irregular interleave of pushes and pops, which checks the occupancy arithmetic. All eight size codes are then tried against all four block limits, and configuration writes are issued with data held and alongside a push, which separates the legality checks from one another. Overflow and underflow bits are raised and cleared, including a clear in the same cycle as a new event.

// File: rtl/rfifo_pkg.sv
`timescale 1ns/1ps
package rfifo_pkg;

  typedef enum logic [1:0] {
    BLK_4   = 2'd0,
    BLK_16  = 2'd1,
    BLK_64  = 2'd2,
    BLK_128 = 2'd3
  } blk_sel_e;

  typedef struct packed {
    logic unf;
    logic ovf;
    logic cfg;
  } err_flags_t;

  function automatic int unsigned code_to_depth(input logic [2:0] code);
    return 32'd1 << code;
  endfunction

  function automatic int unsigned blk_bytes(input logic [1:0] sel);
    blk_sel_e s;
    s = blk_sel_e'(sel);
    case (s)
      BLK_4:   return 32'd4;
      BLK_16:  return 32'd16;
      BLK_64:  return 32'd64;
      default: return 32'd128;
    endcase
  endfunction

endpackage

// File: rtl/rfifo_cfg.sv
`timescale 1ns/1ps
module rfifo_cfg
  import rfifo_pkg::*;
#(
  parameter int CW         = 5,
  parameter int CODE_LIMIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_size,
  input  logic [1:0]    dma_sel,
  input  logic          fifo_empty,
  input  logic          push_req,
  output logic [2:0]    depth_code,
  output logic [CW-1:0] depth,
  output logic          reinit,
  output logic          cfg_bad
);

  logic [2:0] code_q;
  logic       size_ok;
  logic       fits_blk;
  logic       idle_ok;
  logic       legal;

  always_comb begin
    size_ok  = (cfg_size <= 3'(CODE_LIMIT));
    fits_blk = (code_to_depth(cfg_size) <= blk_bytes(dma_sel));
    idle_ok  = fifo_empty && !push_req;
    legal    = size_ok && fits_blk && idle_ok;
    reinit   = cfg_we && legal;
    cfg_bad  = cfg_we && !legal;
  end

  always_ff @(posedge clk) begin
    if (rst)         code_q <= 3'(CODE_LIMIT);
    else if (reinit) code_q <= cfg_size;
  end

  assign depth_code = code_q;
  assign depth      = CW'(code_to_depth(code_q));

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    code_q <= 3'(CODE_LIMIT)); // R4

  AST_CHANGE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_q) |-> $past(fifo_empty && !push_req)); // R6

endmodule

// File: rtl/rfifo_ptrs.sv
`timescale 1ns/1ps
module rfifo_ptrs #(
  parameter int MAX_DEPTH = 16,
  parameter int PW        = $clog2(MAX_DEPTH),
  parameter int CW        = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          reinit,
  input  logic [CW-1:0] depth,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf_evt,
  output logic          unf_evt
);

  logic [CW-1:0] last_idx;
  logic [CW-1:0] count_nxt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p,
                                         input logic [CW-1:0] last);
    if (CW'(p) == last) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    last_idx = depth - 1'b1;
    empty    = (count == '0);
    full     = (count == depth);
    pop_ok   = pop_req && !empty;
    push_ok  = push_req && (!full || pop_ok);
    ovf_evt  = push_req && !push_ok;
    unf_evt  = pop_req && empty;
    case ({push_ok, pop_ok})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || reinit) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr, last_idx);
      if (pop_ok)  rd_ptr <= step(rd_ptr, last_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= depth); // R3

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (push_ok && !pop_ok) |=> count == $past(count) + 1'b1); // R11

  AST_BOTH_AT_FULL: assert property (@(posedge clk) disable iff (rst)
    (full && push_req && pop_req) |=> count == $past(count)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && push_req && !pop_req) |=> $stable(count)); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_req && !push_req) |=> count == '0); // R8

endmodule

// File: rtl/rfifo_store.sv
`timescale 1ns/1ps
module rfifo_store #(
  parameter int DW        = 8,
  parameter int MAX_DEPTH = 16,
  parameter int PW        = $clog2(MAX_DEPTH),
  parameter int CW        = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_ptr,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_ptr,
  input  logic [CW-1:0] depth,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] cells [MAX_DEPTH];

  for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_entry
    logic          enabled;
    logic          hit;
    logic [DW-1:0] q;
    assign enabled = (CW'(i) < depth);
    assign hit     = wr_en && enabled && (wr_ptr == PW'(i));
    always_ff @(posedge clk) begin
      if (hit) q <= wr_data;
    end
    assign cells[i] = q;
  end

  assign rd_data = cells[rd_ptr];

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (CW'(wr_ptr) < depth)); // R7

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    CW'(rd_ptr) < depth); // R7

endmodule

// File: rtl/rfifo_flags.sv
`timescale 1ns/1ps
module rfifo_flags
  import rfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  err_flags_t evt,
  input  err_flags_t clr,
  output err_flags_t flags
);

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr) | evt;
  end

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
    evt.ovf |=> flags.ovf); // R8

  AST_UNF_SETS: assert property (@(posedge clk) disable iff (rst)
    evt.unf |=> flags.unf); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags.cfg && !clr.cfg) |=> flags.cfg); // R9

endmodule

// File: rtl/rsz_byte_fifo.sv
`timescale 1ns/1ps
module rsz_byte_fifo
  import rfifo_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_full,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_size,
  input  logic [1:0]    dma_blk_sel,
  output logic [2:0]    depth_code,
  output logic [$clog2(MAX_DEPTH+1)-1:0] fill_level,
  output logic          err_cfg,
  output logic          err_ovf,
  output logic          err_unf,
  input  logic [2:0]    clr_mask
);

  localparam int PW         = $clog2(MAX_DEPTH);
  localparam int CW         = $clog2(MAX_DEPTH + 1);
  localparam int CODE_LIMIT = $clog2(MAX_DEPTH);

  logic [CW-1:0] depth;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, empty, push_ok, pop_ok, ovf_evt, unf_evt;
  logic          reinit, cfg_bad;
  err_flags_t    evt, clr, flags;

  rfifo_cfg #(.CW(CW), .CODE_LIMIT(CODE_LIMIT)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .dma_sel(dma_blk_sel), .fifo_empty(empty), .push_req(in_valid),
    .depth_code(depth_code), .depth(depth), .reinit(reinit), .cfg_bad(cfg_bad)
  );

  rfifo_ptrs #(.MAX_DEPTH(MAX_DEPTH), .PW(PW), .CW(CW)) u_ptrs (
    .clk(clk), .rst(rst), .push_req(in_valid), .pop_req(out_ready),
    .reinit(reinit), .depth(depth), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .full(full), .empty(empty), .push_ok(push_ok),
    .pop_ok(pop_ok), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  rfifo_store #(.DW(DW), .MAX_DEPTH(MAX_DEPTH), .PW(PW), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .wr_en(push_ok), .wr_ptr(wr_ptr), .wr_data(in_data),
    .rd_ptr(rd_ptr), .depth(depth), .rd_data(out_data)
  );

  assign evt = '{unf: unf_evt, ovf: ovf_evt, cfg: cfg_bad};
  assign clr = '{unf: clr_mask[2], ovf: clr_mask[1], cfg: clr_mask[0]};

  rfifo_flags u_flags (
    .clk(clk), .rst(rst), .evt(evt), .clr(clr), .flags(flags)
  );

  assign in_full    = full;
  assign out_valid  = !empty;
  assign fill_level = count;
  assign err_cfg    = flags.cfg;
  assign err_ovf    = flags.ovf;
  assign err_unf    = flags.unf;

  AST_FILL_CAP: assert property (@(posedge clk) disable iff (rst)
    fill_level <= CW'(MAX_DEPTH)); // R11

  AST_CFG_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !empty) |=> fill_level >= $past(fill_level)); // R6

endmodule

// File: tb/tb_rsz_byte_fifo.sv
`timescale 1ns/1ps
module tb_rsz_byte_fifo;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_full;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready;
  logic       cfg_we;
  logic [2:0] cfg_size;
  logic [1:0] dma_blk_sel;
  logic [2:0] depth_code;
  logic [4:0] fill_level;
  logic       err_cfg, err_ovf, err_unf;
  logic [2:0] clr_mask;

  always #2.5 clk = ~clk;

  rsz_byte_fifo dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_full(in_full), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .dma_blk_sel(dma_blk_sel), .depth_code(depth_code),
    .fill_level(fill_level), .err_cfg(err_cfg), .err_ovf(err_ovf),
    .err_unf(err_unf), .clr_mask(clr_mask)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] mq[$];
  int dep    = 16;
  int code_m = 4;
  bit e_cfg, e_ovf, e_unf;

  function automatic int blk(input int s);
    case (s)
      0: return 4;
      1: return 16;
      2: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R11 fill level", int'(fill_level), mq.size());
    chk("R3 full flag", int'(in_full), int'(mq.size() == dep));
    chk("R2 out_valid", int'(out_valid), int'(mq.size() > 0));
    if (mq.size() > 0) chk("R2 out_data", int'(out_data), int'(mq[0]));
    chk("R4 depth_code", int'(depth_code), code_m);
    chk("R5 err_cfg", int'(err_cfg), int'(e_cfg));
    chk("R8 err_ovf", int'(err_ovf), int'(e_ovf));
    chk("R8 err_unf", int'(err_unf), int'(e_unf));
  endtask

  // One clock cycle with the given stimulus; the model is updated from the pre-edge state.
  task automatic cyc(input bit iv, input logic [7:0] d, input bit rdy,
                     input bit cw, input logic [2:0] cs, input logic [2:0] clr);
    int cnt;
    bit pop_ok, push_ok, legal;
    in_valid = iv; in_data = d; out_ready = rdy;
    cfg_we = cw; cfg_size = cs; clr_mask = clr;
    cnt     = mq.size();
    pop_ok  = rdy && cnt > 0;
    push_ok = iv && (cnt < dep || pop_ok);
    legal   = (cs <= 4) && ((1 << cs) <= blk(int'(dma_blk_sel))) && cnt == 0 && !iv;
    @(posedge clk); #1;
    if (pop_ok)  void'(mq.pop_front());
    if (push_ok) mq.push_back(d);
    if (cw && legal) begin code_m = int'(cs); dep = 1 << cs; end
    e_cfg = (e_cfg && !clr[0]) || (cw && !legal);
    e_ovf = (e_ovf && !clr[1]) || (iv && !push_ok);
    e_unf = (e_unf && !clr[2]) || (rdy && cnt == 0);
    in_valid = 0; out_ready = 0; cfg_we = 0; clr_mask = 0;
    compare_all();
  endtask

  task automatic push(input logic [7:0] d); cyc(1, d, 0, 0, 0, 0); endtask
  task automatic pop();                     cyc(0, 0, 1, 0, 0, 0); endtask
  task automatic setcfg(input logic [2:0] c); cyc(0, 0, 0, 1, c, 0); endtask
  task automatic clrall();                  cyc(0, 0, 0, 0, 0, 3'b111); endtask
  task automatic drain(); while (mq.size() > 0) pop(); endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; out_ready = 0; cfg_we = 0; clr_mask = 0;
    in_data = 0; cfg_size = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    mq.delete(); dep = 16; code_m = 4; e_cfg = 0; e_ovf = 0; e_unf = 0;
    // R1 reset state
    chk("R1 fill", int'(fill_level), 0);
    chk("R1 full", int'(in_full), 0);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 depth_code", int'(depth_code), 4);
    chk("R1 flags", int'({err_cfg, err_ovf, err_unf}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dma_blk_sel = 2'd3;
    do_reset();

    for (int code = 0; code <= 4; code++) begin
      setcfg(3'(code));
      chk("R4 accepted size", int'(depth_code), code);
      // fill to the brim: full must rise exactly at the active depth (R3)
      for (int k = 0; k < dep; k++) push(8'((code * 37 + k * 11 + 5) & 8'hFF));
      chk("R3 full at depth", int'(in_full), 1);
      // extra push while full: dropped, overflow set (R8)
      push(8'hEE);
      chk("R8 overflow set", int'(err_ovf), 1);
      cyc(0, 0, 0, 0, 0, 3'b010);
      chk("R9 overflow cleared", int'(err_ovf), 0);
      // push and pop together at full (R10)
      cyc(1, 8'(code + 200), 1, 0, 0, 0);
      chk("R10 fill stays at depth", int'(fill_level), dep);
      // long pass-through at full to wrap pointers several times (R7)
      for (int k = 0; k < 3 * dep + 1; k++) begin
        chk("R7 order while wrapping", int'(out_data), int'(mq[0]));
        cyc(1, 8'((k * 29 + code) & 8'hFF), 1, 0, 0, 0);
      end
      drain();
      // pop while empty (R8)
      pop();
      chk("R8 underflow set", int'(err_unf), 1);
      cyc(0, 0, 0, 0, 0, 3'b100);
      chk("R9 underflow cleared", int'(err_unf), 0);
      // irregular interleave (R11)
      for (int k = 0; k < 4 * dep + 6; k++)
        cyc(k % 3 != 0, 8'((k * 13 + 1) & 8'hFF), k % 2 == 0, 0, 0, 0);
      drain();
      clrall();
    end

    // size code x block limit sweep on an empty buffer (R4, R5)
    for (int s = 0; s < 4; s++) begin
      dma_blk_sel = 2'(s);
      for (int c = 0; c < 8; c++) begin
        int prev;
        prev = code_m;
        setcfg(3'(c));
        if (c > 4) chk("R4 illegal code ignored", int'(depth_code), prev);
        else if ((1 << c) > blk(s)) chk("R5 over block limit ignored", int'(depth_code), prev);
        else chk("R5 within block limit accepted", int'(depth_code), c);
        chk("R5 error bit", int'(err_cfg), int'(c > 4 || (1 << c) > blk(s)));
        clrall();
      end
    end
    dma_blk_sel = 2'd3;
    setcfg(3'd4);

    // change while data held (R6)
    push(8'h5A); push(8'hA5);
    setcfg(3'd1);
    chk("R6 depth unchanged with data", int'(depth_code), 4);
    chk("R6 error set", int'(err_cfg), 1);
    chk("R6 data kept", int'(out_data), 8'h5A);
    drain();
    clrall();
    // change in same cycle as a push (R6)
    cyc(1, 8'h77, 0, 1, 3'd2, 0);
    chk("R6 depth unchanged with push", int'(depth_code), 4);
    chk("R6 push still taken", int'(fill_level), 1);
    drain();
    clrall();

    // set wins over clear (R9)
    for (int k = 0; k < 16; k++) push(8'(k));
    push(8'h11);
    cyc(1, 8'h22, 0, 0, 0, 3'b010);
    chk("R9 new event beats clear", int'(err_ovf), 1);
    drain();
    clrall();

    // push and pop together while empty: push only, underflow (R11, R8)
    cyc(1, 8'h3C, 1, 0, 0, 0);
    chk("R11 push-only when empty", int'(fill_level), 1);
    chk("R8 underflow on empty pop", int'(err_unf), 1);

    // reset mid-operation (R1)
    setcfg(3'd4);
    push(8'h01);
    do_reset();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule